// File: doc/BRIEF.md
# Timer Status/Control and Decrementer

This block keeps the timer control word and the timer status word of a processor core, together with a 32-bit decrementer and its auto-reload value. Three hardware event sources can set status bits. The first is the decrementer reaching zero. The second is a fixed-interval event pulse. The third is a watchdog event pulse. Each status bit is gated by its own enable bit in the control word, and the result drives one of three level interrupt outputs: decrementer, fixed-interval and watchdog.

Software reaches the four registers through a simple register bus with a 2-bit address, a write enable, write data and combinational read data. Writes take effect at the next rising clock edge. Status bits are cleared by writing ones to them. A separate resume pulse clears the watchdog-related status bits in one step, for use when the core starts running again after a halt. Time-base generation and watchdog reset actions belong to other blocks.

Top module: `tsc_core`

## Requirements
- R1: After synchronous reset, the control word, the status word, the decrementer and the auto-reload value all read 0, and all three interrupt outputs are low.
- R2: The register map is address 0 = control, 1 = status, 2 = decrementer, 3 = auto-reload. The decrementer and auto-reload registers hold all 32 written bits. In the control word only bits 29:28 (watchdog reset control), 27 (watchdog interrupt enable), 26 (decrementer interrupt enable), 23 (fixed-interval interrupt enable) and 22 (auto-reload enable) are stored; all other control bits read 0. In the status word only bits 31:26 exist; bits 25:0 read 0.
- R3: Each interrupt output is the AND of its status bit and its enable bit: decrementer = status 27 and control 26, fixed-interval = status 26 and control 23, watchdog = status 30 and control 27. An output follows a register write from the cycle after the write edge.
- R4: A write to the status register clears every status bit whose write-data bit is 1 and leaves all other status bits unchanged.
- R5: On each time-base tick the decrementer decreases by 1 while it is nonzero. The tick that takes it from 1 to 0 sets status bit 27. With auto-reload off, the decrementer then stays at 0 through further ticks.
- R6: With auto-reload on (control bit 22), the tick that would take the decrementer from 1 to 0 loads the auto-reload value instead. Status bit 27 is still set, and counting continues from the reloaded value.
- R7: A fixed-interval event pulse sets status bit 26.
- R8: A watchdog event pulse sets status bit 31 (watchdog-next-enable) if that bit is clear; otherwise it sets status bit 30 (watchdog interrupt status).
- R9: A resume pulse clears status bits 31:28 and leaves bits 27:26 unchanged.
- R10: When a hardware set and a software clear or resume clear hit the same status bit in the same cycle, the bit ends up set.
- R11: A software write to the decrementer takes priority over a tick in the same cycle. Such a write never sets status bit 27, including a write of 1 or 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected register (combinational) |
| tb_tick | input | 1 | Time-base tick, one cycle per count |
| fit_evt | input | 1 | Fixed-interval event pulse |
| wdt_evt | input | 1 | Watchdog event pulse |
| resume | input | 1 | Clears watchdog status bits |
| irq_dec | output | 1 | Decrementer interrupt level |
| irq_fit | output | 1 | Fixed-interval interrupt level |
| irq_wdt | output | 1 | Watchdog interrupt level |

## Verification
The bench sweeps decrementer start values with auto-reload off and on. An off-by-one in the expiry test would show as status bit 27 set one tick early or late. A missing reload would leave the counter at 0, and a counter that wraps would show a huge value after expiry. All 64 combinations of three status bits and three enable bits are checked against the interrupt outputs, which exposes a swapped bit position or an enable that gates the wrong source. Same-cycle collisions are driven on purpose: a set racing a write-one-to-clear must leave the bit set, and a decrementer write racing a tick must keep the written value and must not set status. The resume pulse and the two-stage watchdog event are checked for bits they must leave alone.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

    parameter int DW = 32;
    parameter int AW = 2;

    typedef enum logic [AW-1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_DCNT = 2'd2,
        REG_RLD  = 2'd3
    } reg_sel_e;

    // status bit positions
    localparam int S_WNX = 31;
    localparam int S_WIS = 30;
    localparam int S_DEC = 27;
    localparam int S_FIT = 26;

    // control bit positions
    localparam int C_WIE = 27;
    localparam int C_DIE = 26;
    localparam int C_FIE = 23;
    localparam int C_ARE = 22;

    localparam logic [DW-1:0] STAT_MASK   = 32'hFC00_0000;
    localparam logic [DW-1:0] CTRL_MASK   = 32'h3CC0_0000;
    localparam logic [DW-1:0] RESUME_MASK = 32'hF000_0000;

    typedef struct packed {
        logic dec;
        logic fit;
        logic wdt;
    } irq_vec_t;

endpackage

// File: rtl/tsc_decr.sv
module tsc_decr #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         auto_rld,
    input  logic [W-1:0] rld_val,
    output logic [W-1:0] cnt,
    output logic         expire
);

    always_comb expire = tick && !load && (cnt == W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (tick && cnt != '0) begin
            if (expire)
                cnt <= auto_rld ? rld_val : '0;
            else
                cnt <= cnt - W'(1);
        end
    end

    assert_step_R5: assert property (@(posedge clk) disable iff (rst)
        (tick && !load && cnt > W'(1)) |=> (cnt == $past(cnt) - W'(1)));

    assert_hold_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt == '0) |=> (cnt == '0));

    assert_reload_R6: assert property (@(posedge clk) disable iff (rst)
        (expire && auto_rld) |=> (cnt == $past(rld_val)));

    assert_load_wins_R11: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(load_val)));

endmodule

// File: rtl/tsc_status.sv
module tsc_status
    import tsc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          dec_evt,
    input  logic          fit_evt,
    input  logic          wdt_evt,
    input  logic          resume,
    input  logic          sw_clr_en,
    input  logic [DW-1:0] sw_clr_data,
    output logic [DW-1:0] stat
);

    logic [DW-1:0] set_m;
    logic [DW-1:0] clr_m;

    always_comb begin
        set_m = '0;
        set_m[S_DEC] = dec_evt;
        set_m[S_FIT] = fit_evt;
        if (wdt_evt) begin
            if (stat[S_WNX]) set_m[S_WIS] = 1'b1;
            else             set_m[S_WNX] = 1'b1;
        end
        clr_m = (sw_clr_en ? sw_clr_data : '0) | (resume ? RESUME_MASK : '0);
    end

    always_ff @(posedge clk) begin
        if (rst) stat <= '0;
        else     stat <= ((stat & ~clr_m) | set_m) & STAT_MASK;
    end

    assert_fit_set_R10: assert property (@(posedge clk) disable iff (rst)
        fit_evt |=> stat[S_FIT]);

    assert_w1c_R4: assert property (@(posedge clk) disable iff (rst)
        (sw_clr_en && sw_clr_data[S_FIT] && !fit_evt) |=> !stat[S_FIT]);

    assert_only_set_R4: assert property (@(posedge clk) disable iff (rst)
        (!sw_clr_en && !resume) |=> ((stat & $past(stat)) == $past(stat)));

    assert_resume_R9: assert property (@(posedge clk) disable iff (rst)
        (resume && !wdt_evt) |=> (stat[31:28] == 4'b0000));

endmodule

// File: rtl/tsc_core.sv
module tsc_core
    import tsc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          tb_tick,
    input  logic          fit_evt,
    input  logic          wdt_evt,
    input  logic          resume,
    output logic          irq_dec,
    output logic          irq_fit,
    output logic          irq_wdt
);

    reg_sel_e      sel;
    logic [DW-1:0] ctrl_q;
    logic [DW-1:0] rld_q;
    logic [DW-1:0] dcnt;
    logic [DW-1:0] stat;
    logic          dec_exp;
    irq_vec_t      irq;

    always_comb sel = reg_sel_e'(bus_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            rld_q  <= '0;
        end else if (bus_we) begin
            if (sel == REG_CTRL) ctrl_q <= bus_wdata & CTRL_MASK;
            if (sel == REG_RLD)  rld_q  <= bus_wdata;
        end
    end

    tsc_decr #(.W(DW)) u_decr (
        .clk      (clk),
        .rst      (rst),
        .tick     (tb_tick),
        .load     (bus_we && sel == REG_DCNT),
        .load_val (bus_wdata),
        .auto_rld (ctrl_q[C_ARE]),
        .rld_val  (rld_q),
        .cnt      (dcnt),
        .expire   (dec_exp)
    );

    tsc_status u_stat (
        .clk         (clk),
        .rst         (rst),
        .dec_evt     (dec_exp),
        .fit_evt     (fit_evt),
        .wdt_evt     (wdt_evt),
        .resume      (resume),
        .sw_clr_en   (bus_we && sel == REG_STAT),
        .sw_clr_data (bus_wdata),
        .stat        (stat)
    );

    always_comb begin
        unique case (sel)
            REG_CTRL: bus_rdata = ctrl_q;
            REG_STAT: bus_rdata = stat;
            REG_DCNT: bus_rdata = dcnt;
            default:  bus_rdata = rld_q;
        endcase
    end

    always_comb begin
        irq.dec = stat[S_DEC] & ctrl_q[C_DIE];
        irq.fit = stat[S_FIT] & ctrl_q[C_FIE];
        irq.wdt = stat[S_WIS] & ctrl_q[C_WIE];
    end

    assign irq_dec = irq.dec;
    assign irq_fit = irq.fit;
    assign irq_wdt = irq.wdt;

    assert_expiry_sets_R5: assert property (@(posedge clk) disable iff (rst)
        dec_exp |=> stat[S_DEC]);

    assert_irq_needs_enable_R3: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q[C_DIE] && !ctrl_q[C_FIE] && !ctrl_q[C_WIE]) |-> !(irq_dec || irq_fit || irq_wdt));

    assert_ctrl_reset_R1: assert property (@(posedge clk)
        $past(rst) |-> (ctrl_q == '0 && stat == '0));

endmodule

// File: tb/sim_tsc_core.sv
module sim_tsc_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  bus_addr = 2'd0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tb_tick = 1'b0;
    logic        fit_evt = 1'b0;
    logic        wdt_evt = 1'b0;
    logic        resume = 1'b0;
    logic        irq_dec, irq_fit, irq_wdt;

    int n_cmp = 0;
    int n_bad = 0;

    localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DCNT = 2'd2, A_RLD = 2'd3;
    localparam logic [31:0] B_DIE = 32'h0400_0000, B_FIE = 32'h0080_0000;
    localparam logic [31:0] B_WIE = 32'h0800_0000, B_ARE = 32'h0040_0000;
    localparam logic [31:0] T_WNX = 32'h8000_0000, T_WIS = 32'h4000_0000;
    localparam logic [31:0] T_DEC = 32'h0800_0000, T_FIT = 32'h0400_0000;

    always #5 clk = ~clk;

    tsc_core u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tb_tick(tb_tick),
        .fit_evt(fit_evt), .wdt_evt(wdt_evt), .resume(resume),
        .irq_dec(irq_dec), .irq_fit(irq_fit), .irq_wdt(irq_wdt)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tb_tick = 1'b1;
            @(negedge clk);
            tb_tick = 1'b0;
        end
    endtask

    task automatic pulse_fit();
        fit_evt = 1'b1; @(negedge clk); fit_evt = 1'b0;
    endtask

    task automatic pulse_wdt();
        wdt_evt = 1'b1; @(negedge clk); wdt_evt = 1'b0;
    endtask

    task automatic check_reset_state(input string tag);
        logic [31:0] v;
        rd(A_CTRL, v); chk({tag, " ctrl"}, v, 32'h0);
        rd(A_STAT, v); chk({tag, " stat"}, v, 32'h0);
        rd(A_DCNT, v); chk({tag, " dcnt"}, v, 32'h0);
        rd(A_RLD,  v); chk({tag, " rld"},  v, 32'h0);
        chk({tag, " irqs"}, {29'd0, irq_dec, irq_fit, irq_wdt}, 32'h0);
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] e;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_reset_state("R1 power-up");

        // R2: register map and stored control bits
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd(A_CTRL, v); chk("R2 ctrl mask", v, 32'h3CC0_0000);
        wr(A_RLD, 32'hA5A5_1234);
        rd(A_RLD, v); chk("R2 reload readback", v, 32'hA5A5_1234);
        wr(A_DCNT, 32'hDEAD_BEEF);
        rd(A_DCNT, v); chk("R2 decr readback", v, 32'hDEAD_BEEF);
        wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_STAT, v); chk("R2 stat unimplemented zero", v, 32'h0);

        // R1: reset again from a busy state
        pulse_fit();
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        check_reset_state("R1 second reset");

        // R5 / R6: decrementer sweep
        for (int are = 0; are < 2; are++) begin
            for (int n = 1; n <= 6; n++) begin
                wr(A_STAT, 32'hFFFF_FFFF);
                wr(A_RLD, 32'd3);
                wr(A_CTRL, are ? B_ARE : 32'h0);
                wr(A_DCNT, n);
                ticks(n - 1);
                rd(A_DCNT, v); chk("R5 count before expiry", v, 32'd1);
                rd(A_STAT, v); chk("R5 no early status", v & T_DEC, 32'h0);
                ticks(1);
                rd(A_STAT, v); chk("R5 status at expiry", v & T_DEC, T_DEC);
                rd(A_DCNT, v); chk(are ? "R6 reload value" : "R5 zero after expiry", v, are ? 32'd3 : 32'd0);
                ticks(1);
                rd(A_DCNT, v); chk(are ? "R6 counts after reload" : "R5 holds zero", v, are ? 32'd2 : 32'd0);
            end
        end

        // R11: write wins over tick, and never sets status
        wr(A_CTRL, 32'h0);
        wr(A_STAT, 32'hFFFF_FFFF);
        wr(A_DCNT, 32'd1);
        tb_tick = 1'b1; wr(A_DCNT, 32'd5); tb_tick = 1'b0;
        rd(A_DCNT, v); chk("R11 write beats tick", v, 32'd5);
        rd(A_STAT, v); chk("R11 no status on write", v, 32'h0);
        wr(A_DCNT, 32'd0);
        rd(A_STAT, v); chk("R11 write zero no status", v, 32'h0);

        // R7 / R8 / R9
        pulse_fit();
        rd(A_STAT, v); chk("R7 fit sets bit26", v, T_FIT);
        pulse_wdt();
        rd(A_STAT, v); chk("R8 first wdt sets next-enable", v, T_FIT | T_WNX);
        pulse_wdt();
        rd(A_STAT, v); chk("R8 second wdt sets int status", v, T_FIT | T_WNX | T_WIS);
        wr(A_DCNT, 32'd1); ticks(1);
        resume = 1'b1; @(negedge clk); resume = 1'b0;
        rd(A_STAT, v); chk("R9 resume clears 31:28 only", v, T_FIT | T_DEC);

        // R4: write-one-to-clear leaves zero-bits alone
        wr(A_STAT, T_FIT);
        rd(A_STAT, v); chk("R4 clear one bit", v, T_DEC);
        wr(A_STAT, 32'h0);
        rd(A_STAT, v); chk("R4 zero write no effect", v, T_DEC);

        // R10: set beats clear in same cycle
        fit_evt = 1'b1; wr(A_STAT, 32'hFFFF_FFFF); fit_evt = 1'b0;
        rd(A_STAT, v); chk("R10 fit set beats w1c", v, T_FIT);
        wr(A_STAT, 32'hFFFF_FFFF);
        pulse_wdt();
        wdt_evt = 1'b1; resume = 1'b1; @(negedge clk); wdt_evt = 1'b0; resume = 1'b0;
        rd(A_STAT, v); chk("R10 wdt set beats resume", v, T_WIS);

        // R3: full status x enable sweep
        for (int s = 0; s < 8; s++) begin
            for (int en = 0; en < 8; en++) begin
                wr(A_CTRL, 32'h0);
                wr(A_STAT, 32'hFFFF_FFFF);
                if (s[0]) begin wr(A_DCNT, 32'd1); ticks(1); end
                if (s[1]) pulse_fit();
                if (s[2]) begin pulse_wdt(); pulse_wdt(); end
                chk("R3 no irq while disabled", {29'd0, irq_dec, irq_fit, irq_wdt}, 32'h0);
                e = 32'h0;
                if (en[0]) e = e | B_DIE;
                if (en[1]) e = e | B_FIE;
                if (en[2]) e = e | B_WIE;
                wr(A_CTRL, e);
                chk("R3 irq and-gating", {29'd0, irq_dec, irq_fit, irq_wdt},
                    {29'd0, s[0] & en[0], s[1] & en[1], s[2] & en[2]});
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule